// File: doc/BRIEF.md
# Lane-wise floating-point compare with mask output

The block compares two 128-bit vector operands element by element under one of eight relational predicates. For each element it returns a truth mask: every bit set when the predicate holds, every bit clear when it does not. A width select treats the operands either as four single-precision elements or as two double-precision elements. A scalar select limits the comparison to the lowest element. In that case the upper part of the result passes through from the first operand.

The predicate is the low three bits of an 8-bit immediate. The result is registered and is qualified by an output strobe one clock after the input strobe. Comparisons follow IEEE-754 ordering. A NaN in either element makes the pair unordered, and both signed zeros compare as equal.

Top module: `simd_fcmp`

## Requirements
- R1: With `dbl`=0 and `scalar`=0, each 32-bit element `[32k+31:32k]` (k=0..3) of the result depends only on the same element of `opa` and `opb`.
- R2: With `dbl`=1 and `scalar`=0, each 64-bit element `[64k+63:64k]` (k=0..1) of the result depends only on the same element of `opa` and `opb`.
- R3: Only `imm[2:0]` selects the predicate. `imm[7:3]` has no effect on the result.
- R4: Predicate codes: 0 a==b, 1 a<b, 2 a<=b, 3 unordered, 4 a!=b, 5 not(a<b), 6 not(a<=b), 7 ordered, with a taken from `opa` and b from `opb`. Each compared element returns all ones when the predicate is true and all zeros when it is false.
- R5: With `scalar`=1, only the lowest element (bits 31:0 single, 63:0 double) is compared. The bits above it are copied unchanged from `opa`.
- R6: A NaN is an element whose exponent is all ones and whose fraction is nonzero. A pair is unordered when either element is a NaN. For such a pair, codes 0, 1, 2 and 7 give false, and codes 3, 4, 5 and 6 give true.
- R7: +0 and -0 compare equal. Non-NaN values, infinities and subnormals included, are ordered by their real value: sign first, then magnitude, with the magnitude order reversed for two negatives.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` updates only on such a cycle and otherwise holds its value. After reset `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operands and controls are valid |
| opa | input | 128 | First operand; source of the pass-through bits in scalar mode |
| opb | input | 128 | Second operand |
| imm | input | 8 | Immediate; bits 2:0 are the predicate code |
| dbl | input | 1 | 0: four single-precision elements, 1: two double-precision elements |
| scalar | input | 1 | 1: compare only the lowest element |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Element masks, plus pass-through bits in scalar mode |

## Verification
The bound checker watches every cycle for the following:
- the one-cycle strobe timing and the holding of the result between strobes;
- the exact pass-through of the upper `opa` bits in both scalar widths;
- the rule that each packed element of a compared result is uniformly ones or zeros;
- the all-ones answer of the unordered predicate whenever a single-precision NaN appears.

Whether a given element ends up ones rather than zeros is shown only by the bench's sweeps. These cover every pair from a set of signed zeros, subnormals, normals, extreme finites, infinities and NaNs, under all eight predicates and both widths. The bench computes each expected mask from a rank assigned to every test value.

// File: rtl/simd_fcmp.sv
module simd_fcmp (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [127:0] opa,
  input  logic [127:0] opb,
  input  logic [7:0]   imm,
  input  logic         dbl,
  input  logic         scalar,
  output logic         out_valid,
  output logic [127:0] result
);
  localparam int VEC_W = 128;
  localparam int SP_W  = 32;
  localparam int DP_W  = 64;
  localparam int SP_N  = VEC_W / SP_W;
  localparam int DP_N  = VEC_W / DP_W;

  // relation code: {unordered, less, equal}
  function automatic logic [2:0] rel_sp(input logic [SP_W-1:0] a, input logic [SP_W-1:0] b);
    logic an, bn;
    an = (a[30:23] == 8'hff) && (a[22:0] != '0);
    bn = (b[30:23] == 8'hff) && (b[22:0] != '0);
    if (an || bn)                            rel_sp = 3'b100;
    else if (a[30:0] == '0 && b[30:0] == '0) rel_sp = 3'b001;
    else if (a == b)                         rel_sp = 3'b001;
    else if (a[31] != b[31])                 rel_sp = {1'b0, a[31], 1'b0};
    else if (!a[31])                         rel_sp = {1'b0, a[30:0] < b[30:0], 1'b0};
    else                                     rel_sp = {1'b0, a[30:0] > b[30:0], 1'b0};
  endfunction

  function automatic logic [2:0] rel_dp(input logic [DP_W-1:0] a, input logic [DP_W-1:0] b);
    logic an, bn;
    an = (a[62:52] == 11'h7ff) && (a[51:0] != '0);
    bn = (b[62:52] == 11'h7ff) && (b[51:0] != '0);
    if (an || bn)                            rel_dp = 3'b100;
    else if (a[62:0] == '0 && b[62:0] == '0) rel_dp = 3'b001;
    else if (a == b)                         rel_dp = 3'b001;
    else if (a[63] != b[63])                 rel_dp = {1'b0, a[63], 1'b0};
    else if (!a[63])                         rel_dp = {1'b0, a[62:0] < b[62:0], 1'b0};
    else                                     rel_dp = {1'b0, a[62:0] > b[62:0], 1'b0};
  endfunction

  function automatic logic holds(input logic [2:0] p, input logic [2:0] r);
    logic un, lt, eq;
    {un, lt, eq} = r;
    case (p)
      3'd0:    holds = eq;
      3'd1:    holds = lt;
      3'd2:    holds = lt | eq;
      3'd3:    holds = un;
      3'd4:    holds = ~eq;
      3'd5:    holds = ~lt;
      3'd6:    holds = ~(lt | eq);
      default: holds = ~un;
    endcase
  endfunction

  logic [2:0]       pred;
  logic [VEC_W-1:0] mask_sp, mask_dp, next_res;
  logic             unused_imm;

  assign pred       = imm[2:0];
  assign unused_imm = ^imm[7:3];

  for (genvar g = 0; g < SP_N; g++) begin : g_sp
    assign mask_sp[g*SP_W +: SP_W] = {SP_W{holds(pred, rel_sp(opa[g*SP_W +: SP_W], opb[g*SP_W +: SP_W]))}};
  end

  for (genvar g = 0; g < DP_N; g++) begin : g_dp
    assign mask_dp[g*DP_W +: DP_W] = {DP_W{holds(pred, rel_dp(opa[g*DP_W +: DP_W], opb[g*DP_W +: DP_W]))}};
  end

  assign next_res = dbl ? (scalar ? {opa[VEC_W-1:DP_W], mask_dp[DP_W-1:0]} : mask_dp)
                        : (scalar ? {opa[VEC_W-1:SP_W], mask_sp[SP_W-1:0]} : mask_sp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/simd_fcmp_chk.sv
module simd_fcmp_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [127:0] opa,
  input logic [127:0] opb,
  input logic [7:0]   imm,
  input logic         dbl,
  input logic         scalar,
  input logic         out_valid,
  input logic [127:0] result
);
  logic nan_lane0;
  assign nan_lane0 = (opa[30:23] == 8'hff && opa[22:0] != '0) || (opb[30:23] == 8'hff && opb[22:0] != '0);

  a_r8_strobe: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  a_r8_quiet:  assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  a_r8_hold:   assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result));
  a_r5_pass_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar && !dbl) |=> result[127:32] == $past(opa[127:32]));
  a_r5_pass_dp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scalar && dbl) |=> result[127:64] == $past(opa[127:64]));
  a_r4_mask_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !scalar && !dbl) |=>
      ((result[31:0] == '0 || result[31:0] == '1) && (result[63:32] == '0 || result[63:32] == '1) &&
       (result[95:64] == '0 || result[95:64] == '1) && (result[127:96] == '0 || result[127:96] == '1)));
  a_r4_mask_dp: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !scalar && dbl) |=>
      ((result[63:0] == '0 || result[63:0] == '1) && (result[127:64] == '0 || result[127:64] == '1)));
  a_r6_unord_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dbl && imm[2:0] == 3'd3 && nan_lane0) |=> result[31:0] == '1);
endmodule

bind simd_fcmp simd_fcmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb), .imm(imm),
  .dbl(dbl), .scalar(scalar), .out_valid(out_valid), .result(result)
);

// File: tb/simd_fcmp_tb.sv
module simd_fcmp_tb;
  localparam int NV = 14;
  logic clk = 0, rst_n = 0, in_valid = 0, dbl = 0, scalar = 0;
  logic [127:0] opa = '0, opb = '0;
  logic [7:0] imm = '0;
  logic out_valid;
  logic [127:0] result;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] sv[NV];
  logic [63:0] dv[NV];
  int rk[NV];
  bit nn[NV];

  always #5 clk = ~clk;

  simd_fcmp u_dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb), .imm(imm),
                   .dbl(dbl), .scalar(scalar), .out_valid(out_valid), .result(result));

  function automatic bit truth(int p, int i, int j);
    bit un, lt, eq;
    un = nn[i] || nn[j];
    lt = !un && rk[i] < rk[j];
    eq = !un && rk[i] == rk[j];
    case (p)
      0: truth = eq;       1: truth = lt;        2: truth = lt || eq;  3: truth = un;
      4: truth = !eq;      5: truth = !lt;       6: truth = !(lt || eq);
      default: truth = !un;
    endcase
  endfunction

  task automatic check(string tag, logic [127:0] exp);
    checks++;
    if (result !== exp || out_valid !== 1'b1) begin
      errors++;
      $display("FAIL %s: got %h (valid %b) expected %h", tag, result, out_valid, exp);
    end
  endtask

  task automatic issue(logic [127:0] a, logic [127:0] b, logic [7:0] im, logic d, logic s);
    @(negedge clk);
    opa = a; opb = b; imm = im; dbl = d; scalar = s; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    sv = '{32'h00000000, 32'h80000000, 32'h3F800000, 32'hBF800000, 32'h40000000, 32'hC0000000,
           32'h7F800000, 32'hFF800000, 32'h7F7FFFFF, 32'hFF7FFFFF, 32'h00000001, 32'h80000001,
           32'h7FC00000, 32'hFF800001};
    dv = '{64'h0, 64'h8000000000000000, 64'h3FF0000000000000, 64'hBFF0000000000000,
           64'h4000000000000000, 64'hC000000000000000, 64'h7FF0000000000000, 64'hFFF0000000000000,
           64'h7FEFFFFFFFFFFFFF, 64'hFFEFFFFFFFFFFFFF, 64'h1, 64'h8000000000000001,
           64'h7FF8000000000000, 64'hFFF0000000000001};
    rk = '{5, 5, 7, 3, 8, 2, 10, 0, 9, 1, 6, 4, 0, 0};
    nn = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};

    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '0) begin
      errors++; $display("FAIL R8 reset: got %b/%h expected 0/0", out_valid, result);
    end
    rst_n = 1;

    // packed single: four independent element pairs
    for (int i = 0; i < NV; i++)
      for (int j = 0; j < NV; j++)
        for (int p = 0; p < 8; p++) begin
          logic [127:0] a, b, e;
          for (int k = 0; k < 4; k++) begin
            int ia = (i + k) % NV, ib = (j + 3 * k) % NV;
            a[k*32 +: 32] = sv[ia]; b[k*32 +: 32] = sv[ib];
            e[k*32 +: 32] = {32{truth(p, ia, ib)}};
          end
          issue(a, b, {5'(i * 3 + j), 3'(p)}, 1'b0, 1'b0);
          check("R1/R4/R6/R7 single packed", e);
        end

    // packed double: two independent element pairs
    for (int i = 0; i < NV; i++)
      for (int j = 0; j < NV; j++)
        for (int p = 0; p < 8; p++) begin
          int i1 = (i + 5) % NV, j1 = (j + 2) % NV;
          issue({dv[i1], dv[i]}, {dv[j1], dv[j]}, {5'(j * 5 + i), 3'(p)}, 1'b1, 1'b0);
          check("R2/R4/R6/R7 double packed", {{64{truth(p, i1, j1)}}, {64{truth(p, i, j)}}});
        end

    // scalar both widths: upper bits come from opa
    for (int i = 0; i < NV; i++)
      for (int j = 0; j < NV; j++)
        for (int p = 0; p < 8; p++) begin
          logic [127:0] up = {32'hDEAD0000 + 32'(i), 32'h1234ABCD ^ 32'(j), 32'(p) << 8, 32'h0};
          issue({up[127:32], sv[i]}, {~up[127:32], sv[j]}, {5'h15, 3'(p)}, 1'b0, 1'b1);
          check("R5 scalar single", {up[127:32], {32{truth(p, i, j)}}});
          issue({up[127:64], dv[i]}, {~up[127:64], dv[j]}, {5'h0A, 3'(p)}, 1'b1, 1'b1);
          check("R5 scalar double", {up[127:64], {64{truth(p, i, j)}}});
        end

    // upper immediate bits swept for fixed operands
    for (int p = 0; p < 8; p++)
      for (int u = 0; u < 32; u++) begin
        issue({sv[3], sv[12], sv[2], sv[0]}, {sv[2], sv[2], sv[2], sv[1]}, {5'(u), 3'(p)}, 1'b0, 1'b0);
        check("R3 imm upper bits", {{32{truth(p, 3, 2)}}, {32{truth(p, 12, 2)}},
                                    {32{truth(p, 2, 2)}}, {32{truth(p, 0, 1)}}});
      end

    // hold: idle cycle with new inputs leaves result untouched
    issue({4{sv[2]}}, {4{sv[4]}}, 8'd1, 1'b0, 1'b0);
    @(negedge clk);
    opa = '0; opb = '1; imm = 8'd0; dbl = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== '1) begin
      errors++; $display("FAIL R8 hold: got %b/%h expected 0/%h", out_valid, result, {128{1'b1}});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule